// File: doc/BRIEF.md
# Bit-level pipelined multiply-accumulate cell

This block computes one multiply-accumulate step for a word-level processing element: it multiplies an M-bit unsigned coefficient by an M-bit unsigned multiplier and adds the product to an accumulate value. The accumulate value is either a partial sum handed over by a neighbouring element or zero, which starts a fresh sum. Every arithmetic cell is an AND-gate partial product feeding a full adder whose sum and carry bits are registered. The block therefore runs as a fine-grained pipeline. It takes a new operand pair on every clock cycle and returns each result a fixed number of cycles later.

The product is reduced by M carry-save rows, one per multiplier bit. The first row is seeded with the accumulate value, so the add costs no extra adder stage. The coefficient moves down the rows one register per row. Each multiplier bit waits in its own delay line until its row is reached, so the bits arrive skewed across the array. A segmented carry-propagate pipeline then merges the sum and carry vectors into a binary result. A demultiplexer at the output sends the result either to the element's own result port or to a forward port that feeds the next element. A valid bit travels with every operand pair.

Top module: `bsmac_array`

## Requirements
- R1: While reset is held and until the first valid operand pair has left the pipeline, `res_valid` and `fwd_valid` are 0 and `res_data` and `fwd_data` are all zeros.
- R2: The delivered value equals the accumulate value plus `in_coef * in_mult`, with all operands taken as unsigned and the result W = 2*M + G bits wide.
- R3: When `in_acc_zero` is 1 the accumulate value is zero and `in_psum` is ignored. When it is 0 the accumulate value is `in_psum`.
- R4: `in_dest` = 0 routes the result to `res_valid`/`res_data`, and `in_dest` = 1 routes it to `fwd_valid`/`fwd_data`. The two valid outputs are never 1 together.
- R5: In any cycle where an output valid is 0, the data bus of that output is all zeros.
- R6: Each result appears exactly M + ceil(W/SEG_W) + 2 clock cycles after the rising edge that samples its operands with `in_valid` = 1. Defaults M = 8, G = 4, SEG_W = 8 give 13 cycles. No output is valid in any other cycle.
- R7: Operand pairs may arrive on every consecutive cycle or with idle gaps of any length. Results come out in arrival order and none is lost or duplicated.
- R8: Each carry-save row keeps the value sum + carry (mod 2^W) equal to its input sum + carry + its partial-product row.
- R9: Each carry-propagate segment keeps the value sum + carry + boundary carry (mod 2^W) unchanged from input to output.
- R10: A result that exceeds 2^W - 1 wraps modulo 2^W. For example, coefficient 255 times multiplier 255 plus accumulate 2^20 - 1 gives 65024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand pair present this cycle |
| in_coef | input | M | Unsigned coefficient |
| in_mult | input | M | Unsigned multiplier |
| in_psum | input | W | Partial sum from the neighbouring element |
| in_acc_zero | input | 1 | 1: accumulate onto zero, 0: accumulate onto in_psum |
| in_dest | input | 1 | 0: deliver to result port, 1: deliver to forward port |
| res_valid | output | 1 | Result port carries a valid value |
| res_data | output | W | Result port value, zero when not valid |
| fwd_valid | output | 1 | Forward port carries a valid value |
| fwd_data | output | W | Forward port value, zero when not valid |

## Verification
The bench sends operands with every bit set together with an all-ones partial sum. This exercises the top carry being dropped and the wrap of R10; a design that kept the carry or stopped it one segment early would return a wrong low word. It mixes back-to-back streams with idle gaps and switches route and accumulate source from one operand pair to the next. A multiplier-bit delay line that is off by one row, or a demultiplexer that follows the current input instead of the pipelined route bit, would then corrupt a neighbouring result or raise the wrong valid. Every idle cycle is checked for quiet outputs and every result for its exact arrival cycle, so a result one cycle early or late, or a pipeline that lost a result, is reported.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  typedef enum logic {
    ROUTE_RESULT  = 1'b0,
    ROUTE_FORWARD = 1'b1
  } route_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bsmac_feed.sv
// Entry stage: picks the accumulate source and skews the multiplier bits.
module bsmac_feed #(
  parameter int unsigned M = 8,
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [M-1:0] coef_i,
  input  logic [M-1:0] mult_i,
  input  logic [W-1:0] psum_i,
  input  logic         acc_zero_i,
  input  logic         dest_i,
  output logic         v_o,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic [M-1:0] coef_o,
  output logic         dest_o,
  output logic [M-1:0] xskew_o
);

  logic [W-1:0] s_d;
  logic [W-1:0] c_d;

  // accumulate-source multiplexer: the sum vector is seeded, carry starts empty
  always_comb begin
    s_d = acc_zero_i ? '0 : psum_i;
    c_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o    <= s_d;
      c_o    <= c_d;
      coef_o <= coef_i;
      dest_o <= dest_i;
    end
  end

  // multiplier bit j waits j+1 registers so it meets row j
  for (genvar j = 0; j < int'(M); j++) begin : g_skew
    logic [j:0] line_q;
    if (j == 0) begin : g_first
      always_ff @(posedge clk) line_q <= mult_i[j];
    end else begin : g_rest
      always_ff @(posedge clk) line_q <= {line_q[j-1:0], mult_i[j]};
    end
    assign xskew_o[j] = line_q[j];
  end

endmodule

// File: rtl/bsmac_csa_row.sv
// One carry-save row: AND partial products into registered full adders.
module bsmac_csa_row #(
  parameter int unsigned M   = 8,
  parameter int unsigned W   = 20,
  parameter int unsigned ROW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [M-1:0] coef_i,
  input  logic         xbit_i,
  input  logic         dest_i,
  output logic         v_o,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic [M-1:0] coef_o,
  output logic         dest_o
);

  logic [W-1:0] pp;
  logic [W-1:0] s_d;
  logic [W-1:0] c_d;

  always_comb begin
    pp       = W'(coef_i & {M{xbit_i}}) << ROW;
    s_d      = s_i ^ c_i ^ pp;
    c_d[0]   = 1'b0;
    c_d[W-1:1] = (s_i[W-2:0] & c_i[W-2:0]) |
                 (s_i[W-2:0] & pp[W-2:0])  |
                 (c_i[W-2:0] & pp[W-2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o    <= s_d;
      c_o    <= c_d;
      coef_o <= coef_i;
      dest_o <= dest_i;
    end
  end

  // R8: redundant value of the row output equals input plus partial products
  assert_row_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> ((s_o + c_o) == $past(s_i + c_i + pp)));

endmodule

// File: rtl/bsmac_cpa_seg.sv
// One carry-propagate segment: resolves SW bits, hands its carry onward.
module bsmac_cpa_seg #(
  parameter int unsigned W  = 20,
  parameter int unsigned LO = 0,
  parameter int unsigned SW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  input  logic         dest_i,
  output logic         v_o,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic         cout_o,
  output logic         dest_o
);

  localparam int unsigned HI = LO + SW;

  logic [SW:0]  add;
  logic [W-1:0] s_d;
  logic [W-1:0] c_d;

  always_comb begin
    add = {1'b0, s_i[LO +: SW]} + {1'b0, c_i[LO +: SW]} + {{SW{1'b0}}, cin_i};
    s_d = s_i;
    c_d = c_i;
    s_d[LO +: SW] = add[SW-1:0];
    c_d[LO +: SW] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o    <= s_d;
      c_o    <= c_d;
      cout_o <= add[SW];
      dest_o <= dest_i;
    end
  end

  // R9: the total value survives each resolution step (mod 2^W)
  assert_seg_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> ((s_o + c_o + ({{(W-1){1'b0}}, cout_o} << HI)) ==
             $past(s_i + c_i + ({{(W-1){1'b0}}, cin_i} << LO))));

endmodule

// File: rtl/bsmac_array.sv
module bsmac_array
  import bsmac_pkg::*;
#(
  parameter int unsigned M     = 8,
  parameter int unsigned G     = 4,
  parameter int unsigned SEG_W = 8,
  localparam int unsigned W    = 2 * M + G
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] in_coef,
  input  logic [M-1:0] in_mult,
  input  logic [W-1:0] in_psum,
  input  logic         in_acc_zero,
  input  logic         in_dest,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data
);

  localparam int unsigned NSEG = ceil_div(W, SEG_W);
  localparam int unsigned LAST = M + NSEG;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // stage k holds data that has passed k+1 registers
  logic         v_p    [0:LAST];
  logic [W-1:0] s_p    [0:LAST];
  logic [W-1:0] c_p    [0:LAST];
  logic         dest_p [0:LAST];
  logic [M-1:0] coef_p [0:M];
  logic [M-1:0] xskew;
  logic         carry  [0:NSEG];
  logic [M-1:0] coef_tail_unused;
  logic         carry_top_unused;

  bsmac_feed #(.M(M), .W(W)) u_feed (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .v_i       (in_valid),
    .coef_i    (in_coef),
    .mult_i    (in_mult),
    .psum_i    (in_psum),
    .acc_zero_i(in_acc_zero),
    .dest_i    (in_dest),
    .v_o       (v_p[0]),
    .s_o       (s_p[0]),
    .c_o       (c_p[0]),
    .coef_o    (coef_p[0]),
    .dest_o    (dest_p[0]),
    .xskew_o   (xskew)
  );

  for (genvar r = 0; r < int'(M); r++) begin : g_row
    bsmac_csa_row #(.M(M), .W(W), .ROW(r)) u_row (
      .clk   (clk),
      .rst_n (rst_int_n),
      .v_i   (v_p[r]),
      .s_i   (s_p[r]),
      .c_i   (c_p[r]),
      .coef_i(coef_p[r]),
      .xbit_i(xskew[r]),
      .dest_i(dest_p[r]),
      .v_o   (v_p[r+1]),
      .s_o   (s_p[r+1]),
      .c_o   (c_p[r+1]),
      .coef_o(coef_p[r+1]),
      .dest_o(dest_p[r+1])
    );
  end
  assign coef_tail_unused = coef_p[M];

  assign carry[0] = 1'b0;
  for (genvar s = 0; s < int'(NSEG); s++) begin : g_seg
    localparam int unsigned LO = s * SEG_W;
    localparam int unsigned SW = (W - LO < SEG_W) ? (W - LO) : SEG_W;
    bsmac_cpa_seg #(.W(W), .LO(LO), .SW(SW)) u_seg (
      .clk   (clk),
      .rst_n (rst_int_n),
      .v_i   (v_p[M+s]),
      .s_i   (s_p[M+s]),
      .c_i   (c_p[M+s]),
      .cin_i (carry[s]),
      .dest_i(dest_p[M+s]),
      .v_o   (v_p[M+s+1]),
      .s_o   (s_p[M+s+1]),
      .c_o   (c_p[M+s+1]),
      .cout_o(carry[s+1]),
      .dest_o(dest_p[M+s+1])
    );
  end
  assign carry_top_unused = carry[NSEG];

  // output demultiplexer
  logic         res_valid_d, fwd_valid_d;
  logic [W-1:0] res_data_d,  fwd_data_d;

  always_comb begin
    res_valid_d = v_p[LAST] && (route_e'(dest_p[LAST]) == ROUTE_RESULT);
    fwd_valid_d = v_p[LAST] && (route_e'(dest_p[LAST]) == ROUTE_FORWARD);
    res_data_d  = res_valid_d ? s_p[LAST] : '0;
    fwd_data_d  = fwd_valid_d ? s_p[LAST] : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid <= 1'b0;
      fwd_valid <= 1'b0;
      res_data  <= '0;
      fwd_data  <= '0;
    end else begin
      res_valid <= res_valid_d;
      fwd_valid <= fwd_valid_d;
      res_data  <= res_data_d;
      fwd_data  <= fwd_data_d;
    end
  end

  // R4: a result goes to one destination only
  assert_one_route_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({res_valid, fwd_valid}));

  // R5: quiet buses when not valid
  assert_res_quiet_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !res_valid |-> (res_data == '0));
  assert_fwd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fwd_valid |-> (fwd_data == '0));

endmodule

// File: tb/bsmac_array_bench.sv
module bsmac_array_bench;

  localparam int unsigned M     = 8;
  localparam int unsigned G     = 4;
  localparam int unsigned SEG_W = 8;
  localparam int unsigned W     = 2 * M + G;
  localparam int          LAT   = M + (W + SEG_W - 1) / SEG_W + 2;

  typedef struct {
    logic [W-1:0] data;
    logic         dest;
    int           due;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [M-1:0] in_coef;
  logic [M-1:0] in_mult;
  logic [W-1:0] in_psum;
  logic         in_acc_zero;
  logic         in_dest;
  logic         res_valid;
  logic [W-1:0] res_data;
  logic         fwd_valid;
  logic [W-1:0] fwd_data;

  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bsmac_array #(.M(M), .G(G), .SEG_W(SEG_W)) u_bsmac_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .in_mult(in_mult), .in_psum(in_psum), .in_acc_zero(in_acc_zero),
    .in_dest(in_dest), .res_valid(res_valid), .res_data(res_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic send(input logic [M-1:0] a, input logic [M-1:0] x,
                      input logic [W-1:0] p, input logic zero,
                      input logic dest, input string req);
    exp_t e;
    logic [W-1:0] acc;
    @(negedge clk);
    in_valid = 1'b1; in_coef = a; in_mult = x; in_psum = p;
    in_acc_zero = zero; in_dest = dest;
    acc    = zero ? '0 : p;
    e.data = acc + (W'(a) * W'(x));
    e.dest = dest;
    e.due  = cyc + LAT;
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_coef = $urandom; in_mult = $urandom; in_psum = W'($urandom);
      in_acc_zero = $urandom; in_dest = $urandom;
    end
  endtask

  // monitor: scoreboard pop and compare at the exact due cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.dest) begin
          check(fwd_valid == 1'b1, e.req, "R4 fwd_valid", W'(fwd_valid), 1);
          check(fwd_data == e.data, e.req, "R2 fwd_data", fwd_data, e.data);
          check(res_valid == 1'b0 && res_data == '0, e.req, "R5 res quiet", res_data, 0);
        end else begin
          check(res_valid == 1'b1, e.req, "R4 res_valid", W'(res_valid), 1);
          check(res_data == e.data, e.req, "R2 res_data", res_data, e.data);
          check(fwd_valid == 1'b0 && fwd_data == '0, e.req, "R5 fwd quiet", fwd_data, 0);
        end
      end else begin
        check(!res_valid && !fwd_valid, "R6", "no result due",
              W'({res_valid, fwd_valid}), 0);
        check(res_data == '0 && fwd_data == '0, "R5", "idle data",
              res_data | fwd_data, 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; in_mult = '0;
    in_psum = '0; in_acc_zero = 1'b0; in_dest = 1'b0;
    repeat (3) @(negedge clk);
    check(!res_valid && !fwd_valid && res_data == '0 && fwd_data == '0,
          "R1", "reset state", res_data | fwd_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!res_valid && !fwd_valid, "R1", "after release", W'({res_valid, fwd_valid}), 0);
    mon_en = 1'b1;

    // directed cases (R8 and R9 act on every one of these)
    send(8'd3, 8'd5, 20'd7, 1'b0, 1'b0, "R2");
    send(8'd200, 8'd100, 20'd12345, 1'b1, 1'b0, "R3");
    send(8'd17, 8'd0, 20'd999, 1'b0, 1'b1, "R4");
    send(8'd0, 8'd255, 20'd4242, 1'b0, 1'b1, "R8");
    send(8'd255, 8'd255, 20'hFFFFF, 1'b0, 1'b0, "R10");
    send(8'd255, 8'd255, 20'hFFFFF, 1'b0, 1'b1, "R9");
    send(8'd128, 8'd1, 20'hFF, 1'b0, 1'b0, "R9");
    idle(LAT + 2);
    send(8'd1, 8'd1, 20'd0, 1'b1, 1'b0, "R6");
    idle(LAT + 2);

    // back-to-back stream
    for (int i = 0; i < 300; i++)
      send(M'($urandom), M'($urandom), W'($urandom), 1'($urandom), 1'($urandom), "R7");
    // stream with random gaps
    for (int i = 0; i < 300; i++) begin
      send(M'($urandom), M'($urandom), W'($urandom), 1'($urandom), 1'($urandom), "R7");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 4));
    end
    idle(LAT + 4);
    check(q.size() == 0, "R7", "all results drained", W'(q.size()), 0);
    finish_run();
  end

endmodule